// File: doc/BRIEF.md
# DisplayPort AUX Request Controller

This block runs a single DisplayPort AUX channel transaction at a time on behalf of software. Software first fills up to sixteen payload bytes into four 32-bit write-data words. It then writes a command word with the request code, the 20-bit AUX address and the length, and finally sets the go bit in the control register. The controller turns the command into a header byte stream and appends the payload for write requests. The stream goes out over a valid/ready byte handshake to an external AUX PHY, which handles line coding and signalling.

Reply bytes come back from the PHY as a pushed byte stream terminated by a last flag. The first reply byte is the reply code. Any later bytes land in four read-data words, and the status register reports the reply code, the number of bytes received, an accepted-byte count for a partially taken I2C write, and a timeout flag. The go bit reads back as busy and drops by itself when the transaction ends or times out, so software completes a request by polling. An active-low soft reset bit in a separate register aborts a hung transaction.

Top module: `aux_req_ctrl`

## Requirements
- R1: After reset the status register (0x78) and the control register (0x74) read 0, the soft-reset register (0x700) reads 0x10, and tx_valid is low.
- R2: A request's first header bytes are, in order: {cmd[3:0], addr[19:16]}, addr[15:8], addr[7:0], where the command word (0x50) holds the request code in bits 3:0 and the address in bits 27:8. When bit 28 is clear, a fourth header byte carries the length field (byte count minus one, bits 7:4) in its low nibble.
- R3: When command bit 28 is set (address only), only the three address header bytes are sent and no payload follows.
- R4: For a write request (code bit 0 equal to 0, bit 28 clear), the header is followed by length-field+1 payload bytes, taken little-endian from the write words at 0x54, 0x58, 0x5C and 0x60 (byte 0 is bits 7:0 of 0x54). Read requests (code bit 0 equal to 1) send only the header.
- R5: tx_last is high on the final byte of the request stream and on no other byte. tx_data and tx_last hold steady while tx_valid waits for tx_ready.
- R6: The first reply byte is reported in status bits 11:4. Status bits 16:12 count all received reply bytes, including the code byte. Reply data bytes are packed little-endian into the read words at 0x64, 0x68, 0x6C and 0x70.
- R7: Control bit 0 reads 1 from the cycle after go is written until the transaction ends, and it clears when the PHY delivers the reply byte flagged last.
- R8: With the timer enable (control bit 2) set, a reply that has not arrived TIMEOUT_CYC cycles after the last request byte sets status bit 0 and clears control bit 0. With the timer enable clear, the controller waits indefinitely.
- R9: For an I2C write request (code bits 3 and 1:0 all zero), the reply byte that follows the reply code is stored in status bits 24:17. For other requests these bits read 0.
- R10: Writes to the command word or to the write words while a transaction is in progress are ignored.
- R11: Starting a transaction clears the status register and the read words. Both then keep their values after the transaction ends, until the next start.
- R12: Writing 0 to bit 4 of register 0x700 aborts any transaction, drops tx_valid and blocks new starts until the bit is written back to 1.
- R13: The control register reads back the sync-length select (bit 1), the timer enable (bit 2) and the 5-bit minimum pulse count (bits 13:9) as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| tx_valid | output | 1 | Request byte available to the PHY |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final byte of the request |
| tx_ready | input | 1 | PHY accepts the current request byte |
| rx_valid | input | 1 | Reply byte from the PHY |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Final byte of the reply |

## Verification
The bench keeps four data words (sixteen payload bytes) and shortens the reply timeout to 24 cycles. The short timeout lets the expiry be watched both well before and just after the limit, and lets the indefinite wait with the timer disabled run well past it. The full data width makes the sixteen-byte write stream, the seventeen-byte read reply and the clearing of read words left over from a longer earlier reply reachable in a short run.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    localparam logic [11:0] OFS_CMD  = 12'h050;
    localparam logic [11:0] OFS_WDAT = 12'h054;
    localparam logic [11:0] OFS_CTRL = 12'h074;
    localparam logic [11:0] OFS_STAT = 12'h078;
    localparam logic [11:0] OFS_RST  = 12'h700;

    function automatic logic is_i2c_write(input logic [3:0] code);
        return (code[3] == 1'b0) && (code[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/aux_frame_mux.sv
module aux_frame_mux #(
    parameter int DATA_WORDS = 4,
    localparam int MAXB = 4 * DATA_WORDS,
    localparam int IW = $clog2(MAXB + 5)
) (
    input  logic [31:0]          cmd,
    input  logic [MAXB*8-1:0]    wdat,
    input  logic [IW-1:0]        idx,
    output logic [7:0]           byte_o,
    output logic                 last_o
);
    logic addr_only;
    int   hdr_len;
    int   pay_len;
    int   pidx;

    always_comb begin
        addr_only = cmd[28];
        hdr_len   = addr_only ? 3 : 4;
        pay_len   = (!addr_only && !cmd[0]) ? (int'(cmd[7:4]) + 1) : 0;
        pidx      = int'(idx) - hdr_len;
        byte_o    = 8'h00;
        case (int'(idx))
            0: byte_o = {cmd[3:0], cmd[27:24]};
            1: byte_o = cmd[23:16];
            2: byte_o = cmd[15:8];
            3: byte_o = addr_only ? wdat[7:0] : {4'h0, cmd[7:4]};
            default: begin
                if (pidx >= 0 && pidx < MAXB)
                    byte_o = wdat[8*pidx +: 8];
            end
        endcase
        last_o = (int'(idx) == hdr_len + pay_len - 1);
    end
endmodule

// File: rtl/aux_reply_timer.sv
module aux_reply_timer #(
    parameter int LIMIT = 40000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        expired = run && !clear && (cnt_q == CW'(LIMIT - 1));
        if (clear || !run)
            cnt_d = '0;
        else if (!expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/aux_req_ctrl.sv
module aux_req_ctrl
    import aux_req_pkg::*;
#(
    parameter int DATA_WORDS  = 4,
    parameter int TIMEOUT_CYC = 40000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last
);
    localparam int MAXB = 4 * DATA_WORDS;
    localparam int IW   = $clog2(MAXB + 5);
    localparam logic [11:0] OFS_RDAT = OFS_WDAT + 12'(4 * DATA_WORDS);

    typedef struct packed {
        phase_e            phase;
        logic [IW-1:0]     idx;
        logic [31:0]       cmd;
        logic [MAXB*8-1:0] wdat;
        logic [MAXB*8-1:0] rdat;
        logic              cfg_sync;
        logic              cfg_timer;
        logic [4:0]        cfg_pulse;
        logic              aux_rstn;
        logic              to_flag;
        logic [7:0]        rcode;
        logic [4:0]        rcnt;
        logic [7:0]        part;
    } state_t;

    state_t s_d, s_q;
    logic   busy;
    logic   fr_last;
    logic   tmr_exp;
    logic [7:0] fr_byte;

    aux_frame_mux #(.DATA_WORDS(DATA_WORDS)) u_mux (
        .cmd    (s_q.cmd),
        .wdat   (s_q.wdat),
        .idx    (s_q.idx),
        .byte_o (fr_byte),
        .last_o (fr_last)
    );

    aux_reply_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.phase == PH_WAIT && s_q.cfg_timer),
        .clear   (rx_valid),
        .expired (tmr_exp)
    );

    assign busy     = (s_q.phase != PH_IDLE) && s_q.aux_rstn;
    assign tx_valid = (s_q.phase == PH_SEND) && s_q.aux_rstn;
    assign tx_data  = fr_byte;
    assign tx_last  = fr_last;

    always_comb begin
        int bi;
        s_d = s_q;
        bi  = int'(s_q.rcnt) - 1;

        case (s_q.phase)
            PH_SEND: begin
                if (tx_ready) begin
                    if (fr_last) s_d.phase = PH_WAIT;
                    else         s_d.idx   = s_q.idx + 1'b1;
                end
            end
            PH_WAIT: begin
                if (rx_valid) begin
                    if (s_q.rcnt == '0)
                        s_d.rcode = rx_data;
                    else if (int'(s_q.rcnt) <= MAXB)
                        s_d.rdat[8*bi +: 8] = rx_data;
                    if (s_q.rcnt == 5'd1 && is_i2c_write(s_q.cmd[3:0]))
                        s_d.part = rx_data;
                    if (int'(s_q.rcnt) < MAXB + 1)
                        s_d.rcnt = s_q.rcnt + 1'b1;
                    if (rx_last)
                        s_d.phase = PH_IDLE;
                end else if (tmr_exp) begin
                    s_d.to_flag = 1'b1;
                    s_d.phase   = PH_IDLE;
                end
            end
            default: ;
        endcase

        if (bus_wr) begin
            if (bus_addr == OFS_RST)
                s_d.aux_rstn = bus_wdata[4];
            if (bus_addr == OFS_CTRL) begin
                s_d.cfg_sync  = bus_wdata[1];
                s_d.cfg_timer = bus_wdata[2];
                s_d.cfg_pulse = bus_wdata[13:9];
                if (bus_wdata[0] && !busy && s_q.aux_rstn) begin
                    s_d.phase   = PH_SEND;
                    s_d.idx     = '0;
                    s_d.to_flag = 1'b0;
                    s_d.rcode   = '0;
                    s_d.rcnt    = '0;
                    s_d.part    = '0;
                    s_d.rdat    = '0;
                end
            end
            if (!busy) begin
                if (bus_addr == OFS_CMD)
                    s_d.cmd = bus_wdata;
                for (int k = 0; k < DATA_WORDS; k++)
                    if (bus_addr == OFS_WDAT + 12'(4 * k))
                        s_d.wdat[32*k +: 32] = bus_wdata;
            end
        end

        if (!s_q.aux_rstn) begin
            s_d.phase = PH_IDLE;
            s_d.idx   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.aux_rstn <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CMD:  bus_rdata = s_q.cmd;
            OFS_CTRL: bus_rdata = {18'b0, s_q.cfg_pulse, 6'b0, s_q.cfg_timer, s_q.cfg_sync, busy};
            OFS_STAT: bus_rdata = {7'b0, s_q.part, s_q.rcnt, s_q.rcode, 3'b0, s_q.to_flag};
            OFS_RST:  bus_rdata = {27'b0, s_q.aux_rstn, 4'b0};
            default: begin
                for (int k = 0; k < DATA_WORDS; k++) begin
                    if (bus_addr == OFS_WDAT + 12'(4 * k)) bus_rdata = s_q.wdat[32*k +: 32];
                    if (bus_addr == OFS_RDAT + 12'(4 * k)) bus_rdata = s_q.rdat[32*k +: 32];
                end
            end
        endcase
    end
endmodule

// File: rtl/aux_req_chk.sv
module aux_req_chk #(
    parameter int MAX_RCNT = 17
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_last,
    input logic       to_flag,
    input logic [4:0] rcnt
);
    a_r5_tx_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    a_r5_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && busy) |=>
            (!busy || (tx_valid && $stable(tx_data) && $stable(tx_last))));

    a_r5_stream_ends_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    a_r8_timeout_ends_txn: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> !busy);

    a_r11_start_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rcnt == 5'd0 && !to_flag));

    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rcnt) <= MAX_RCNT);
endmodule

bind aux_req_ctrl aux_req_chk #(.MAX_RCNT(4 * DATA_WORDS + 1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .to_flag  (s_q.to_flag),
    .rcnt     (s_q.rcnt)
);

// File: tb/aux_req_ctrl_test.sv
module aux_req_ctrl_test;
    localparam int TO = 24;
    localparam logic [11:0] A_CMD = 12'h050, A_WD0 = 12'h054, A_RD0 = 12'h064,
                            A_CTRL = 12'h074, A_STAT = 12'h078, A_RST = 12'h700;
    localparam logic [31:0] GO_NT = 32'h0000_1201;
    localparam logic [31:0] GO_T  = 32'h0000_1205;

    // {cmd, frame length, reply length, reply code}
    localparam logic [55:0] VEC [6] = '{
        {32'h0123_4538, 8'd8,  8'd1,  8'h00},
        {32'h0000_50F1, 8'd4,  8'd17, 8'h00},
        {32'h0001_0059, 8'd4,  8'd7,  8'h00},
        {32'h0000_5014, 8'd6,  8'd1,  8'h00},
        {32'h1000_5005, 8'd3,  8'd1,  8'h00},
        {32'h0FFF_FFF8, 8'd20, 8'd1,  8'h20}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic tx_valid, tx_last, tx_ready = 1'b1;
    logic [7:0] tx_data;
    logic rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0] rx_data = '0;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    aux_req_ctrl #(.DATA_WORDS(4), .TIMEOUT_CYC(TO)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [7:0] exp_byte(input logic [31:0] cmd, input int k);
        int hdr = cmd[28] ? 3 : 4;
        case (k)
            0: return {cmd[3:0], cmd[27:24]};
            1: return cmd[23:16];
            2: return cmd[15:8];
            default: return (k == 3 && hdr == 4) ? {4'h0, cmd[7:4]} : 8'((k - hdr) * 17);
        endcase
    endfunction

    // R2 R3 R4 R5: collect the request stream and compare byte by byte
    task automatic collect(input logic [31:0] cmd, input int flen);
        int k = 0;
        bit done = 0;
        tx_ready = 1'b1;
        for (int g = 0; g < 64 && !done; g++) begin
            if (tx_valid) begin
                chk("R2/R4 request byte", {24'h0, tx_data}, {24'h0, exp_byte(cmd, k)});
                chk("R5 tx_last position", {31'h0, tx_last}, {31'h0, k == flen - 1});
                if (tx_last) done = 1;
                k++;
            end
            @(negedge clk);
        end
        chk("R3/R4 frame length", 32'(k), 32'(flen));
    endtask

    task automatic reply(input int n, input logic [7:0] code, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = (i == 0) ? code : 8'(base + i - 1);
            rx_last  = (i == n - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        bus_read(A_STAT, d); chk("R1 status", d, 32'h0);
        bus_read(A_CTRL, d); chk("R1 control", d, 32'h0);
        bus_read(A_RST, d);  chk("R1 soft reset reg", d, 32'h10);
        chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);

        // R13 config readback without start
        bus_write(A_CTRL, 32'h0000_1206);
        bus_read(A_CTRL, d); chk("R13 config readback", d, 32'h0000_1206);
        chk("R13 no start", {31'h0, tx_valid}, 32'h0);

        bus_write(A_WD0,      32'h3322_1100);
        bus_write(A_WD0 + 4,  32'h7766_5544);
        bus_write(A_WD0 + 8,  32'hBBAA_9988);
        bus_write(A_WD0 + 12, 32'hFFEE_DDCC);

        // Vector table: R2 R3 R4 R5 R6 R7 R11
        for (int v = 0; v < 6; v++) begin
            logic [31:0] cmd = VEC[v][55:24];
            int flen = int'(VEC[v][23:16]);
            int rlen = int'(VEC[v][15:8]);
            logic [7:0] code = VEC[v][7:0];
            bus_write(A_CMD, cmd);
            bus_write(A_CTRL, GO_NT);
            bus_read(A_CTRL, d); chk("R7 busy after go", {31'h0, d[0]}, 32'h1);
            collect(cmd, flen);
            bus_read(A_CTRL, d); chk("R7 busy awaiting reply", {31'h0, d[0]}, 32'h1);
            reply(rlen, code, 8'hA0);
            bus_read(A_CTRL, d); chk("R7 busy cleared", {31'h0, d[0]}, 32'h0);
            bus_read(A_STAT, d);
            chk("R6 status after reply", d, {7'h0, 8'h00, 5'(rlen), code, 4'h0});
            for (int w = 0; w < 4; w++) begin
                e = '0;
                for (int b = 0; b < 4; b++)
                    if (4 * w + b < rlen - 1) e[8*b +: 8] = 8'(8'hA0 + 4 * w + b);
                bus_read(A_RD0 + 12'(4 * w), d);
                chk("R6/R11 read word", d, e);
            end
        end

        // R9 partial I2C write
        bus_write(A_CMD, 32'h0000_5030);
        bus_write(A_CTRL, GO_NT);
        collect(32'h0000_5030, 8);
        reply(2, 8'h40, 8'h02);
        bus_read(A_STAT, d); chk("R9 partial count", d, {7'h0, 8'h02, 5'd2, 8'h40, 4'h0});

        // R10 writes ignored while busy
        tx_ready = 1'b0;
        bus_write(A_CMD, 32'h0001_0059);
        bus_write(A_CTRL, GO_NT);
        bus_write(A_CMD, 32'h0ABC_DEF9);
        bus_write(A_WD0, 32'hDEAD_BEEF);
        bus_read(A_CMD, d); chk("R10 cmd kept", d, 32'h0001_0059);
        bus_read(A_WD0, d); chk("R10 write word kept", d, 32'h3322_1100);
        chk("R5 stalled byte held", {24'h0, tx_data}, 32'h90);
        collect(32'h0001_0059, 4);
        reply(1, 8'h00, 8'hA0);

        // R8 timeout with timer enabled, R11 hold after
        bus_write(A_CTRL, GO_T);
        collect(32'h0001_0059, 4);
        repeat (TO / 2) @(negedge clk);
        bus_read(A_CTRL, d); chk("R8 still waiting", {31'h0, d[0]}, 32'h1);
        bus_read(A_STAT, d); chk("R8 no early timeout", d, 32'h0);
        repeat (TO) @(negedge clk);
        bus_read(A_CTRL, d); chk("R8 busy cleared on timeout", {31'h0, d[0]}, 32'h0);
        bus_read(A_STAT, d); chk("R8 timeout flag", d, 32'h1);
        repeat (10) @(negedge clk);
        bus_read(A_STAT, d); chk("R11 status held", d, 32'h1);

        // R8 timer disabled waits indefinitely
        bus_write(A_CTRL, GO_NT);
        collect(32'h0001_0059, 4);
        repeat (3 * TO) @(negedge clk);
        bus_read(A_CTRL, d); chk("R8 no timer keeps waiting", {31'h0, d[0]}, 32'h1);
        reply(1, 8'h00, 8'hA0);
        bus_read(A_STAT, d); chk("R8 no timeout flag", d, {19'h0, 5'd1, 8'h00, 4'h0} >> 0);

        // R12 soft reset abort
        tx_ready = 1'b0;
        bus_write(A_CTRL, GO_NT);
        chk("R12 sending before abort", {31'h0, tx_valid}, 32'h1);
        bus_write(A_RST, 32'h0);
        chk("R12 tx dropped", {31'h0, tx_valid}, 32'h0);
        bus_read(A_CTRL, d); chk("R12 busy dropped", {31'h0, d[0]}, 32'h0);
        bus_write(A_CTRL, GO_NT);
        bus_read(A_CTRL, d); chk("R12 start blocked", {31'h0, d[0]}, 32'h0);
        bus_write(A_RST, 32'h10);
        bus_read(A_RST, d); chk("R12 reset released", d, 32'h10);
        bus_write(A_CTRL, GO_NT);
        collect(32'h0001_0059, 4);
        reply(1, 8'h00, 8'hA0);
        bus_read(A_CTRL, d); chk("R12 recovered", {31'h0, d[0]}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule